// File: doc/BRIEF.md
# Multi-Function Port Pin Controller

This block holds the digital control for a port of bidirectional pins, each of which can be a plain I/O or can serve a peripheral. A small write interface loads four per-pin configuration registers: output value, direction, pull-up and open-drain. For each pin, the block decides what the pad should do. It chooses the output value from the port register or from one of two peripheral outputs: a serial slave-select output and a comparator output. It then produces separate enables for the high-side (PMOS) driver, the low-side (NMOS) driver, the pull-up and the input buffer.

On the input side, the pad level feeds the CPU read path and four peripheral inputs: slave select, external interrupt, event counter and pin-change detect. A fixed priority sets each pin's mode, from highest to lowest: analog channel, secondary input, driven output, listening input. Because of this, the pad drive and the input gating cannot be read from the direction bit alone. A port-wide debug enable forces every pin to open-drain behaviour.

The pad itself, the analog path and any input filter live outside the block. The block drives only the enables and reads back the pad level.

Top module: `gpio_mf_port`

## Requirements
- R1: After reset, every configuration register is 0. With no alternate function enabled and the read strobe high, no driver is enabled, the pull-up is off, the input buffer is off, every peripheral input is 1 and a read returns 0.
- R2: When wr_en is high at a clock edge, wr_data is loaded into the register chosen by wr_sel, and it takes effect from that edge. The selector codes are 0 = output value, 1 = direction (1 = output), 2 = pull-up, 3 = open-drain.
- R3: pull_en for each pin equals that pin's pull-up register bit, whatever its direction, mode or alternate enables.
- R4: A driven pin that is not in open-drain mode works push-pull. An output value of 1 enables only the PMOS driver, and a value of 0 enables only the NMOS driver.
- R5: A pin is in open-drain mode when its open-drain bit is set or dbg_en is high. In that mode the PMOS driver is never enabled, and a value of 1 leaves both drivers off.
- R6: The output value is ss_out when the pin's ss_out_en is set. Otherwise it is cmp_out when the pin's cmp_out_en is set. Otherwise it is the output-value register bit.
- R7: A pin whose ss_out_en or cmp_out_en is set is driven even when its direction bit is 0.
- R8: If any secondary-input enable or ana_en is set for a pin, both of its drivers are off, whatever its direction or peripheral output enables.
- R9: With any secondary-input enable set and ana_en clear, the input buffer is on continuously. With none set, it is on only while rd_n is low.
- R10: ana_en turns the input buffer off. This overrides every other input enable, including rd_n.
- R11: rd_data returns the output-value register bit for a pin whose direction bit is 1. For a pin whose direction bit is 0, it returns the pad level while the input buffer is on, and 0 otherwise.
- R12: Each peripheral input (ss_in, int_in, cnt_in, pchg_in) carries the pad level when its own enable is set and the input buffer is on. In every other case it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector |
| wr_data | input | W | Write data, one bit per pin |
| rd_n | input | 1 | CPU port read strobe, active low |
| dbg_en | input | 1 | Debug mode, forces open-drain on all pins |
| ss_out | input | 1 | Slave-select output from serial peripheral |
| ss_out_en | input | W | Per-pin slave-select output enable |
| cmp_out | input | 1 | Comparator output |
| cmp_out_en | input | W | Per-pin comparator output enable |
| ss_in_en | input | W | Per-pin slave-select input enable |
| int_en | input | W | Per-pin external interrupt input enable |
| cnt_en | input | W | Per-pin event counter input enable |
| pchg_en | input | W | Per-pin pin-change input enable |
| ana_en | input | W | Per-pin analog channel enable |
| pad_in | input | W | Pad level |
| drv_hi_en | output | W | PMOS driver enable |
| drv_lo_en | output | W | NMOS driver enable |
| pull_en | output | W | Pull-up enable |
| ibuf_en | output | W | Input buffer enable |
| rd_data | output | W | CPU read data |
| ss_in | output | W | Slave-select input to peripheral |
| int_in | output | W | External interrupt input |
| cnt_in | output | W | Event counter input |
| pchg_in | output | W | Pin-change input |

## Verification
Two functions can fall on the same pin in the same cycle. One is a CPU read, with rd_n low. The other is a secondary-input or analog enable taking over the pin. Both also compete with a driven direction, and the enable changes the pad's drive, the buffer gating and the read value all at once. The bench provokes these collisions in directed steps and in a random phase that draws sparse enable masks while rd_n toggles. An external bench driver sets the pad whenever the pin does not drive it. Each sample is compared against enable, read and peripheral-input values that a bench model computes from the priority order in the requirements.

// File: rtl/gpio_mf_pkg.sv
package gpio_mf_pkg;
    typedef enum logic [1:0] {
        SEL_VALUE = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PULL  = 2'd2,
        SEL_ODRN  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PM_ANALOG,
        PM_SECIN,
        PM_DRIVE,
        PM_LISTEN
    } pin_mode_e;
endpackage

// File: rtl/gpio_mf_regs.sv
module gpio_mf_regs
    import gpio_mf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pull_q,
    output logic [W-1:0] odrn_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            dir_q   <= '0;
            pull_q  <= '0;
            odrn_q  <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_VALUE: value_q <= wr_data;
                SEL_DIR:   dir_q   <= wr_data;
                SEL_PULL:  pull_q  <= wr_data;
                SEL_ODRN:  odrn_q  <= wr_data;
            endcase
        end
    end

    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> dir_q == $past(wr_data));
    a_r2_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(value_q));
endmodule

// File: rtl/gpio_mf_pin.sv
module gpio_mf_pin
    import gpio_mf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic value_bit,
    input  logic dir_bit,
    input  logic pull_bit,
    input  logic odrn_bit,
    input  logic dbg_en,
    input  logic ss_out,
    input  logic ss_out_en,
    input  logic cmp_out,
    input  logic cmp_out_en,
    input  logic ss_in_en,
    input  logic int_en,
    input  logic cnt_en,
    input  logic pchg_en,
    input  logic ana_en,
    input  logic rd_n,
    input  logic pad_in,
    output logic drv_hi_en,
    output logic drv_lo_en,
    output logic pull_en,
    output logic ibuf_en,
    output logic rd_bit,
    output logic ss_in,
    output logic int_in,
    output logic cnt_in,
    output logic pchg_in
);
    pin_mode_e mode;
    logic      sec_any;
    logic      per_out;
    logic      out_val;
    logic      od_eff;
    logic      pad_seen;

    assign sec_any = ss_in_en | int_en | cnt_en | pchg_en;
    assign per_out = ss_out_en | cmp_out_en;
    assign od_eff  = odrn_bit | dbg_en;
    assign pull_en = pull_bit;

    always_comb begin
        if (ss_out_en)       out_val = ss_out;
        else if (cmp_out_en) out_val = cmp_out;
        else                 out_val = value_bit;
    end

    always_comb begin
        if (ana_en)                 mode = PM_ANALOG;
        else if (sec_any)           mode = PM_SECIN;
        else if (dir_bit | per_out) mode = PM_DRIVE;
        else                        mode = PM_LISTEN;
    end

    always_comb begin
        drv_hi_en = 1'b0;
        drv_lo_en = 1'b0;
        ibuf_en   = 1'b0;
        unique case (mode)
            PM_ANALOG: ibuf_en = 1'b0;
            PM_SECIN:  ibuf_en = 1'b1;
            PM_DRIVE: begin
                ibuf_en   = ~rd_n;
                drv_hi_en = out_val & ~od_eff;
                drv_lo_en = ~out_val;
            end
            PM_LISTEN: ibuf_en = ~rd_n;
        endcase
    end

    assign pad_seen = ibuf_en & pad_in;
    assign rd_bit   = dir_bit ? value_bit : pad_seen;
    assign ss_in    = (ibuf_en & ss_in_en) ? pad_in : 1'b1;
    assign int_in   = (ibuf_en & int_en)   ? pad_in : 1'b1;
    assign cnt_in   = (ibuf_en & cnt_en)   ? pad_in : 1'b1;
    assign pchg_in  = (ibuf_en & pchg_en)  ? pad_in : 1'b1;

    a_r5_no_pmos_in_od: assert property (@(posedge clk) disable iff (!rst_n)
        (odrn_bit || dbg_en) |-> !drv_hi_en);
    a_r8_override_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_en || ss_in_en || int_en || cnt_en || pchg_en) |-> (!drv_hi_en && !drv_lo_en));
    a_r10_analog_ibuf_off: assert property (@(posedge clk) disable iff (!rst_n)
        ana_en |-> !ibuf_en);
    a_r12_sec_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !ibuf_en |-> (ss_in && int_in && cnt_in && pchg_in));
    a_r4_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_hi_en && drv_lo_en));
endmodule

// File: rtl/gpio_mf_port.sv
module gpio_mf_port
    import gpio_mf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         rd_n,
    input  logic         dbg_en,
    input  logic         ss_out,
    input  logic [W-1:0] ss_out_en,
    input  logic         cmp_out,
    input  logic [W-1:0] cmp_out_en,
    input  logic [W-1:0] ss_in_en,
    input  logic [W-1:0] int_en,
    input  logic [W-1:0] cnt_en,
    input  logic [W-1:0] pchg_en,
    input  logic [W-1:0] ana_en,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] drv_hi_en,
    output logic [W-1:0] drv_lo_en,
    output logic [W-1:0] pull_en,
    output logic [W-1:0] ibuf_en,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] ss_in,
    output logic [W-1:0] int_in,
    output logic [W-1:0] cnt_in,
    output logic [W-1:0] pchg_in
);
    logic [W-1:0] value_q, dir_q, pull_q, odrn_q;

    gpio_mf_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .value_q (value_q),
        .dir_q   (dir_q),
        .pull_q  (pull_q),
        .odrn_q  (odrn_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_mf_pin u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .value_bit  (value_q[i]),
            .dir_bit    (dir_q[i]),
            .pull_bit   (pull_q[i]),
            .odrn_bit   (odrn_q[i]),
            .dbg_en     (dbg_en),
            .ss_out     (ss_out),
            .ss_out_en  (ss_out_en[i]),
            .cmp_out    (cmp_out),
            .cmp_out_en (cmp_out_en[i]),
            .ss_in_en   (ss_in_en[i]),
            .int_en     (int_en[i]),
            .cnt_en     (cnt_en[i]),
            .pchg_en    (pchg_en[i]),
            .ana_en     (ana_en[i]),
            .rd_n       (rd_n),
            .pad_in     (pad_in[i]),
            .drv_hi_en  (drv_hi_en[i]),
            .drv_lo_en  (drv_lo_en[i]),
            .pull_en    (pull_en[i]),
            .ibuf_en    (ibuf_en[i]),
            .rd_bit     (rd_data[i]),
            .ss_in      (ss_in[i]),
            .int_in     (int_in[i]),
            .cnt_in     (cnt_in[i]),
            .pchg_in    (pchg_in[i])
        );
    end

    a_r3_pull_tracks_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> pull_en == $past(wr_data));
endmodule

// File: tb/tb_gpio_mf_port.sv
module tb_gpio_mf_port;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic         rd_n = 1'b1;
    logic         dbg_en = 1'b0;
    logic         ss_out = 1'b0;
    logic         cmp_out = 1'b0;
    logic [W-1:0] ss_out_en = '0, cmp_out_en = '0, ss_in_en = '0;
    logic [W-1:0] int_en = '0, cnt_en = '0, pchg_en = '0, ana_en = '0;
    logic [W-1:0] ext_en = '0, ext_val = '0;
    wire  [W-1:0] pad;
    logic [W-1:0] drv_hi_en, drv_lo_en, pull_en, ibuf_en, rd_data;
    logic [W-1:0] ss_in, int_in, cnt_in, pchg_in;

    logic [W-1:0] m_value = '0, m_dir = '0, m_pull = '0, m_odrn = '0;
    logic [W-1:0] e_hi, e_lo, e_ibuf, e_rd, e_ss, e_int, e_cnt, e_pchg;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < W; i++) begin : g_pad
        assign pad[i] = drv_lo_en[i] ? 1'b0 :
                        drv_hi_en[i] ? 1'b1 :
                        ext_en[i]    ? ext_val[i] :
                        pull_en[i];
    end

    gpio_mf_port #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_n(rd_n), .dbg_en(dbg_en), .ss_out(ss_out), .ss_out_en(ss_out_en),
        .cmp_out(cmp_out), .cmp_out_en(cmp_out_en), .ss_in_en(ss_in_en),
        .int_en(int_en), .cnt_en(cnt_en), .pchg_en(pchg_en), .ana_en(ana_en),
        .pad_in(pad), .drv_hi_en(drv_hi_en), .drv_lo_en(drv_lo_en), .pull_en(pull_en),
        .ibuf_en(ibuf_en), .rd_data(rd_data), .ss_in(ss_in), .int_in(int_in),
        .cnt_in(cnt_in), .pchg_in(pchg_in)
    );

    task automatic model();
        for (int i = 0; i < W; i++) begin
            logic sec, drive, v, od, buf_on;
            sec    = ss_in_en[i] | int_en[i] | cnt_en[i] | pchg_en[i];
            drive  = !ana_en[i] && !sec && (m_dir[i] || ss_out_en[i] || cmp_out_en[i]);
            v      = ss_out_en[i] ? ss_out : (cmp_out_en[i] ? cmp_out : m_value[i]);
            od     = m_odrn[i] | dbg_en;
            buf_on = !ana_en[i] && (sec || !rd_n);
            e_hi[i]   = drive && v && !od;
            e_lo[i]   = drive && !v;
            e_ibuf[i] = buf_on;
            e_rd[i]   = m_dir[i] ? m_value[i] : (buf_on ? pad[i] : 1'b0);
            e_ss[i]   = (buf_on && ss_in_en[i]) ? pad[i] : 1'b1;
            e_int[i]  = (buf_on && int_en[i])   ? pad[i] : 1'b1;
            e_cnt[i]  = (buf_on && cnt_en[i])   ? pad[i] : 1'b1;
            e_pchg[i] = (buf_on && pchg_en[i])  ? pad[i] : 1'b1;
        end
    endtask

    task automatic cmp1(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        #2;
        model();
        cmp1(tag, "drv_hi_en", drv_hi_en, e_hi);
        cmp1(tag, "drv_lo_en", drv_lo_en, e_lo);
        cmp1(tag, "pull_en", pull_en, m_pull);
        cmp1(tag, "ibuf_en", ibuf_en, e_ibuf);
        cmp1(tag, "rd_data", rd_data, e_rd);
        cmp1(tag, "ss_in", ss_in, e_ss);
        cmp1(tag, "int_in", int_in, e_int);
        cmp1(tag, "cnt_in", cnt_in, e_cnt);
        cmp1(tag, "pchg_in", pchg_in, e_pchg);
    endtask

    task automatic wr(logic [1:0] sel, logic [W-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        unique case (sel)
            2'd0: m_value = val;
            2'd1: m_dir   = val;
            2'd2: m_pull  = val;
            2'd3: m_odrn  = val;
        endcase
    endtask

    task automatic clear_alt();
        @(negedge clk);
        ss_out_en = '0; cmp_out_en = '0; ss_in_en = '0; int_en = '0;
        cnt_en = '0; pchg_en = '0; ana_en = '0; dbg_en = 1'b0; rd_n = 1'b1;
        ext_en = '0; ext_val = '0;
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hA5);
        check_all("R2");
        check_all("R4");

        wr(2'd3, 8'h0F);
        check_all("R5");
        wr(2'd3, 8'h00);
        @(negedge clk); dbg_en = 1'b1;
        check_all("R5");
        clear_alt();

        wr(2'd2, 8'h3C);
        @(negedge clk); ana_en = 8'h30; int_en = 8'h04;
        check_all("R3");
        clear_alt();

        @(negedge clk); ss_out_en = 8'h03; cmp_out_en = 8'h06; ss_out = 1'b0; cmp_out = 1'b1;
        check_all("R6");
        clear_alt();

        wr(2'd1, 8'h00);
        @(negedge clk); cmp_out_en = 8'hF0; cmp_out = 1'b0;
        check_all("R7");
        clear_alt();

        wr(2'd1, 8'hFF);
        @(negedge clk); int_en = 8'h01; ana_en = 8'h02; cmp_out_en = 8'h03; rd_n = 1'b0;
        check_all("R8");
        clear_alt();

        wr(2'd1, 8'h00);
        @(negedge clk); pchg_en = 8'h10; ext_en = 8'hFF; ext_val = 8'h5A;
        check_all("R9");
        @(negedge clk); rd_n = 1'b0;
        check_all("R9");
        check_all("R11");

        @(negedge clk); ana_en = 8'hFF; ss_in_en = 8'hFF; rd_n = 1'b0;
        check_all("R10");
        clear_alt();

        wr(2'd1, 8'hF0);
        @(negedge clk); ext_en = 8'hFF; ext_val = 8'h96; ss_in_en = 8'h01; int_en = 8'h02;
        cnt_en = 8'h04; pchg_en = 8'h08;
        check_all("R12");
        @(negedge clk); ext_val = 8'h69;
        check_all("R12");
        clear_alt();

        for (int n = 0; n < 400; n++) begin
            if (($urandom % 3) == 0) wr(2'($urandom), W'($urandom));
            @(negedge clk);
            ss_out_en  = W'($urandom) & W'($urandom);
            cmp_out_en = W'($urandom) & W'($urandom);
            ss_in_en   = W'($urandom) & W'($urandom) & W'($urandom);
            int_en     = W'($urandom) & W'($urandom) & W'($urandom);
            cnt_en     = W'($urandom) & W'($urandom) & W'($urandom);
            pchg_en    = W'($urandom) & W'($urandom) & W'($urandom);
            ana_en     = W'($urandom) & W'($urandom) & W'($urandom);
            ss_out  = 1'($urandom);
            cmp_out = 1'($urandom);
            dbg_en  = (($urandom % 5) == 0);
            rd_n    = 1'($urandom);
            ext_en  = W'($urandom);
            ext_val = W'($urandom);
            check_all("R11/R12 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule